// File: doc/BRIEF.md
# Four-Channel PWM Generator with Committed Settings

This block drives several independent pulse-width outputs from one input clock. Each channel cascades two dividers. A prescaler turns the clock into slow ticks, and a period counter counts those ticks. The output stays high for a programmed number of ticks at the start of every period. Software sets each channel through two 32-bit words on a single-cycle register bus.

Divider and duty writes only land in a staging copy. They reach the running counters when software sets a self-clearing commit flag. A running channel swaps in the new values at the end of its current period, so no shortened or split pulse appears. An idle channel takes them on the next clock. The enable flag is live. Clearing it forces the output low and resets the channel's counters. Setting it again starts a fresh period.

Top module: `pwm_bank`

## Requirements
- R1: After reset every output is low and every register word reads zero.
- R2: Channel c has a timing word at byte address 8c and a control word at 8c+4. The timing word holds the period divider in [15:0] and the high count in [31:16]. The control word holds the prescaler in [15:0], the commit flag in bit 30 and the enable flag in bit 31. Reads return the staged values, unused bits read zero, and address bits [1:0] are ignored.
- R3: A committed channel with prescaler P, period divider D and high count H repeats every (P+1)*(D+1) clocks. Each period begins with H*(P+1) high clocks, and the rest of the period is low.
- R4: Channels run independently. Programming one channel leaves the waveform of every other channel unchanged.
- R5: Writing staged values without the commit flag leaves the running waveform unchanged.
- R6: On a running channel, a commit takes effect at the next period boundary. The commit flag reads 1 until then. It reads 0 from the first cycle of the new period, and the output shows the new high phase from that same cycle.
- R7: A high count of zero holds the output low.
- R8: A high count greater than the period divider holds the output high without a break.
- R9: Writing the enable flag as 0 forces the output low from the next cycle and resets the counters. Writing it as 1 keeps the output low for one more cycle, and a fresh period with its high phase then starts.
- R10: On a channel whose enable has been clear for at least one cycle, a commit is applied at the next clock edge, and the flag then reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for counters and registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address of the register word |
| bus_we | input | 1 | Write strobe, captured on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH (4) | One pulse output per channel |

## Verification
Call E0 the edge that captures a write. A cleared enable shows on the output in the sample right after E0. An idle channel applies its commit at the next edge (E1): its commit flag reads 0 in the sample after E1, and a freshly enabled channel starts its high phase there. On a running channel, the bench polls the commit flag once per cycle. It then checks that the output is high in the very sample where the flag first reads 0, and it measures the high run that follows. All waveform checks sample on the falling edge and count high cycles over windows that are whole periods long. A correct result therefore does not depend on phase, while a period or duty error of even one clock changes the count.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
   localparam int WORD_W   = 32;
   localparam int FIELD_W  = 16;  // widest divider a register field can hold
   localparam int HI_LSB   = 16;  // high count position in the timing word
   localparam int UPD_BIT  = 30;  // commit flag in the control word
   localparam int EN_BIT   = 31;  // enable flag in the control word
   localparam int CH_STRIDE_LOG2 = 3; // eight bytes per channel
endpackage

// File: rtl/pwm_bank_regs.sv
`timescale 1ns/1ps
module pwm_bank_regs
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int CNT_W  = 16,
   parameter int WA_W   = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [WA_W-1:0]               word_addr,
   input  logic                          we,
   input  logic [WORD_W-1:0]             wdata,
   output logic [WORD_W-1:0]             rdata,
   output logic [NUM_CH-1:0][CNT_W-1:0]  stg_hi,
   output logic [NUM_CH-1:0][CNT_W-1:0]  stg_per,
   output logic [NUM_CH-1:0][CNT_W-1:0]  stg_pre,
   output logic [NUM_CH-1:0]             en_q,
   output logic [NUM_CH-1:0]             upd_q,
   input  logic [NUM_CH-1:0]             ack
);
   localparam int CH_W = WA_W - 1;

   logic            word_sel;
   logic [CH_W-1:0] ch_idx;

   assign word_sel = word_addr[0];
   assign ch_idx   = word_addr[WA_W-1:1];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic sel_tim, sel_ctl;
      assign sel_tim = we && (ch_idx == CH_W'(c)) && !word_sel;
      assign sel_ctl = we && (ch_idx == CH_W'(c)) &&  word_sel;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg_hi[c]  <= '0;
            stg_per[c] <= '0;
            stg_pre[c] <= '0;
            upd_q[c]   <= 1'b0;
            en_q[c]    <= 1'b0;
         end else begin
            if (sel_tim) begin
               stg_hi[c]  <= wdata[HI_LSB +: CNT_W];
               stg_per[c] <= wdata[0 +: CNT_W];
            end
            if (sel_ctl) begin
               stg_pre[c] <= wdata[0 +: CNT_W];
               upd_q[c]   <= wdata[UPD_BIT];
               en_q[c]    <= wdata[EN_BIT];
            end else if (ack[c]) begin
               upd_q[c]   <= 1'b0;
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (ch_idx == CH_W'(c)) begin
            if (!word_sel) begin
               rdata[HI_LSB +: CNT_W] = stg_hi[c];
               rdata[0 +: CNT_W]      = stg_per[c];
            end else begin
               rdata[0 +: CNT_W]      = stg_pre[c];
               rdata[UPD_BIT]         = upd_q[c];
               rdata[EN_BIT]          = en_q[c];
            end
         end
      end
   end
endmodule

// File: rtl/pwm_bank_chan.sv
`timescale 1ns/1ps
module pwm_bank_chan #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             upd_i,
   input  logic [CNT_W-1:0] stg_pre,
   input  logic [CNT_W-1:0] stg_per,
   input  logic [CNT_W-1:0] stg_hi,
   output logic             ack_o,
   output logic             pwm_o
);
   logic             run_q;
   logic [CNT_W-1:0] pre_cnt, per_cnt;
   logic [CNT_W-1:0] act_pre, act_per, act_hi;
   logic             tick, wrap;

   assign tick  = (pre_cnt == act_pre);
   assign wrap  = tick && (per_cnt == act_per);
   // commit lands at a period boundary, or at once while idle
   assign ack_o = upd_i && (!run_q || wrap);
   assign pwm_o = en_i && run_q && (per_cnt < act_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         pre_cnt <= '0;
         per_cnt <= '0;
         act_pre <= '0;
         act_per <= '0;
         act_hi  <= '0;
      end else begin
         run_q <= en_i;
         if (ack_o) begin
            act_pre <= stg_pre;
            act_per <= stg_per;
            act_hi  <= stg_hi;
         end
         if (!run_q || !en_i) begin
            pre_cnt <= '0;
            per_cnt <= '0;
         end else if (tick) begin
            pre_cnt <= '0;
            per_cnt <= wrap ? '0 : per_cnt + 1'b1;
         end else begin
            pre_cnt <= pre_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwm_bank.sv
`timescale 1ns/1ps
module pwm_bank
   import pwm_bank_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int DIV_W  = 16,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam int ADDR_W = CH_W + CH_STRIDE_LOG2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [WORD_W-1:0] bus_wdata,
   output logic [WORD_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] pwm_out
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("pwm_bank: NUM_CH must be at least 1");
   end
   if (DIV_W < 1 || DIV_W > FIELD_W) begin : g_bad_w
      $error("pwm_bank: DIV_W must lie in 1..16");
   end

   localparam int WA_W = ADDR_W - 2;

   logic [NUM_CH-1:0][DIV_W-1:0] cfg_hi, cfg_per, cfg_pre;
   logic [NUM_CH-1:0]            en_bits, upd_bits, ack_bits;

   pwm_bank_regs #(
      .NUM_CH (NUM_CH),
      .CNT_W  (DIV_W),
      .WA_W   (WA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .word_addr (bus_addr[ADDR_W-1:2]),
      .we        (bus_we),
      .wdata     (bus_wdata),
      .rdata     (bus_rdata),
      .stg_hi    (cfg_hi),
      .stg_per   (cfg_per),
      .stg_pre   (cfg_pre),
      .en_q      (en_bits),
      .upd_q     (upd_bits),
      .ack       (ack_bits)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      pwm_bank_chan #(
         .CNT_W (DIV_W)
      ) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .en_i    (en_bits[c]),
         .upd_i   (upd_bits[c]),
         .stg_pre (cfg_pre[c]),
         .stg_per (cfg_per[c]),
         .stg_hi  (cfg_hi[c]),
         .ack_o   (ack_bits[c]),
         .pwm_o   (pwm_out[c])
      );
   end
endmodule

// File: rtl/pwm_bank_chk.sv
`timescale 1ns/1ps
module pwm_bank_chk #(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic              wr_en_bit,
   input logic [NUM_CH-1:0] pwm_out,
   input logic [NUM_CH-1:0] en_bits,
   input logic [NUM_CH-1:0] upd_bits,
   input logic [NUM_CH-1:0] ack_bits
);
   for (genvar c = 0; c < NUM_CH; c++) begin : g_p
      logic ctl_wr;
      assign ctl_wr = bus_we && (bus_addr == ADDR_W'(8 * c + 4));

      // R9
      en_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ctl_wr && !wr_en_bit) |=> !pwm_out[c]);

      // R6
      upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_bits[c] && !ctl_wr) |=> !upd_bits[c]);

      // R10
      idle_apply_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (upd_bits[c] && !en_bits[c] && $past(!en_bits[c])) |-> ack_bits[c]);

      // R9
      rise_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(pwm_out[c]) |-> $past(en_bits[c]));
   end
endmodule

bind pwm_bank pwm_bank_chk #(
   .NUM_CH (NUM_CH),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .wr_en_bit (bus_wdata[31]),
   .pwm_out   (pwm_out),
   .en_bits   (en_bits),
   .upd_bits  (upd_bits),
   .ack_bits  (ack_bits)
);

// File: tb/pwm_bank_test.sv
`timescale 1ns/1ps
module pwm_bank_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  pwm_out;

   int nvec = 0;
   int nfail = 0;

   always #4 clk = ~clk;

   pwm_bank uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pwm_out   (pwm_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nvec++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic count_high(input int ch, input int n, output int h);
      h = 0;
      repeat (n) begin
         @(negedge clk);
         if (pwm_out[ch]) h++;
      end
   endtask

   // poll the commit flag once per cycle until it clears
   task automatic wait_apply(input logic [4:0] a, input int lim, output int n);
      logic [31:0] d;
      n = 0;
      rd(a, d);
      while (d[30] && n < lim) begin
         @(negedge clk);
         n++;
         rd(a, d);
      end
   endtask

   task automatic t_reset;
      logic [31:0] d;
      chk("R1 outputs", {28'd0, pwm_out}, 32'd0);
      for (int i = 0; i < 8; i++) begin
         rd(5'(i * 4), d);
         chk("R1 register", d, 32'd0);
      end
   endtask

   task automatic t_basic;
      logic [31:0] d;
      int h, h0, h1, lo2;
      wr(5'd0,  {16'd2, 16'd4});
      wr(5'd8,  {16'd1, 16'd2});
      wr(5'd12, 32'hC000_0000);
      wr(5'd4,  32'hC000_0001);
      count_high(0, 4, h);
      chk("R3 high phase at period start", h, 4);
      count_high(0, 6, h);
      chk("R3 low phase", h, 0);
      h0 = 0; h1 = 0; lo2 = 0;
      repeat (30) begin
         @(negedge clk);
         if (pwm_out[0]) h0++;
         if (pwm_out[1]) h1++;
         if (pwm_out[2]) lo2++;
      end
      chk("R3 ch0 over three periods", h0, 12);
      chk("R4 ch1 own waveform", h1, 10);
      chk("R4 idle ch2 stays low", lo2, 0);
      rd(5'd0, d);  chk("R2 timing word", d, {16'd2, 16'd4});
      rd(5'd12, d); chk("R2 control word", d, 32'h8000_0000);
      rd(5'd13, d); chk("R2 low address bits ignored", d, 32'h8000_0000);
      rd(5'd4, d);  chk("R2 control word ch0", d, 32'h8000_0001);
   endtask

   task automatic t_staged;
      logic [31:0] d;
      int h, n;
      wr(5'd0, {16'd5, 16'd9});
      count_high(0, 20, h);
      chk("R5 staged write without commit", h, 8);
      rd(5'd0, d);
      chk("R2 read returns staged", d, {16'd5, 16'd9});
      wr(5'd4, 32'hC000_0001);
      rd(5'd4, d);
      chk("R6 flag pending", {31'd0, d[30]}, 32'd1);
      @(negedge clk);
      wait_apply(5'd4, 40, n);
      chk("R6 applied within one period", {31'd0, (n <= 10)}, 32'd1);
      chk("R6 new period starts high", {31'd0, pwm_out[0]}, 32'd1);
      count_high(0, 9, h);
      chk("R6 new high run", h, 9);
      count_high(0, 10, h);
      chk("R6 new low run", h, 0);
      count_high(0, 40, h);
      chk("R3 prescaled period", h, 20);
   endtask

   task automatic t_extremes;
      int h, n;
      wr(5'd0, {16'd0, 16'd3});
      wr(5'd4, 32'hC000_0000);
      wait_apply(5'd4, 40, n);
      count_high(0, 8, h);
      chk("R7 zero high count", h, 0);
      wr(5'd0, {16'd3, 16'd3});
      wr(5'd4, 32'hC000_0000);
      wait_apply(5'd4, 40, n);
      count_high(0, 8, h);
      chk("R3 high count equal to divider", h, 6);
      wr(5'd0, {16'd4, 16'd3});
      wr(5'd4, 32'hC000_0000);
      wait_apply(5'd4, 40, n);
      count_high(0, 8, h);
      chk("R8 high count above divider", h, 8);
   endtask

   task automatic t_disable;
      logic [31:0] d;
      int h;
      wr(5'd4, 32'h0000_0000);
      chk("R9 low right after disable", {31'd0, pwm_out[0]}, 32'd0);
      count_high(0, 10, h);
      chk("R9 stays low", h, 0);
      wr(5'd0, {16'd3, 16'd7});
      wr(5'd4, 32'h4000_0001);
      @(negedge clk);
      rd(5'd4, d);
      chk("R10 idle commit clears", d, 32'h0000_0001);
      wr(5'd4, 32'h8000_0001);
      chk("R9 low in enable cycle", {31'd0, pwm_out[0]}, 32'd0);
      count_high(0, 6, h);
      chk("R9 fresh high run", h, 6);
      count_high(0, 10, h);
      chk("R9 fresh low run", h, 0);
      count_high(0, 32, h);
      chk("R10 committed values used", h, 12);
   endtask

   initial begin
      #1_000_000;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_staged();
      t_extremes();
      t_disable();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end
endmodule